// File: doc/BRIEF.md
# Dual-Channel DAC Frame Sequencer

This block keeps a two-channel 12-bit serial DAC continuously refreshed. It runs a fixed frame of 40 serial-clock slots. Within each frame it sends a 16-bit command word for channel A under one chip-select window, then releases chip select for a short gap. It then sends a 16-bit command word for channel B under a second window. After a short quiet interval it pulses the active-low load strobe, so that both analog outputs change together.

Two 12-bit sample inputs are copied into holding registers on the first system clock of every frame. Whatever the inputs do during the rest of the frame has no effect on the words being sent. A one-cycle `frame_done` pulse marks each frame boundary. Upstream waveform logic uses it to prepare the next pair of samples. The serial clock is made from the system clock by a clock enable. Every slot lasts `2*HALF_DIV` system clocks.

Top module: `dac_frame_seq`

## Requirements
- R1: A frame is 40 slots of `2*HALF_DIV` system clocks. Counting rising clock edges after reset release as e = 1, 2, ..., slot number (e / (2*HALF_DIV)) mod 40 is visible after edge e. `frame_done` is high for exactly one cycle after each edge that is a nonzero multiple of `80*HALF_DIV`, and low at all other times.
- R2: `cs_n` is low exactly during slots 2 to 17 (channel A) and 22 to 37 (channel B). It is high during slots 0-1, 18-21, 38 and 39.
- R3: While `cs_n` is low, `sck` is low for the first half of each slot and high for the second half. While `cs_n` is high, `sck` stays low.
- R4: `mosi` changes only at slot starts, so it is stable whenever `sck` is high. Each word goes out MSB first, one bit per slot. `mosi` is 0 whenever `cs_n` is high.
- R5: The command word is {channel, 0, 1, 1, sample[11:0]}. Bit 15 is 0 for channel A and 1 for channel B. Bit 14 is 0. Bit 13 (gain 1x) is 1. Bit 12 (output enabled) is 1. Bits 11:0 carry the sample. Channel A words therefore read 0x3000+sample and channel B words read 0xB000+sample.
- R6: `ldac_n` is low for exactly slot 39, a single slot of `2*HALF_DIV` system clocks, and `cs_n` is high throughout.
- R7: `samp_a` and `samp_b` are sampled only at the rising edge that ends the first cycle of a frame. That is edge 1 after reset, and after that the edge that ends each `frame_done` cycle. Input changes at any other time do not alter that frame's words.
- R8: While `rst` is high, `cs_n`=1, `ldac_n`=1, `sck`=0, `mosi`=0 and `frame_done`=0. A reset in mid-frame restarts the schedule at slot 0.
- R9: Each `sck` high and low half-period inside a word lasts exactly `HALF_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_a | input | 12 | Channel A sample, captured at frame start |
| samp_b | input | 12 | Channel B sample, captured at frame start |
| sck | output | 1 | Serial clock to the DAC |
| mosi | output | 1 | Serial data to the DAC |
| cs_n | output | 1 | Active-low chip select |
| ldac_n | output | 1 | Active-low output latch strobe |
| frame_done | output | 1 | One-cycle pulse at each frame boundary |

## Verification
The sample pairs include all-zeros against all-ones on opposite channels, which exposes swapped channels and inverted data. Alternating 0xA5A/0x5A5 patterns reveal bit-order and off-by-one shift faults. The pair 0x800/0x001 separates MSB from LSB misplacement, and irregular values catch stuck header bits. After every capture, the bench drives the inverted next samples until mid-frame, which shows whether capture happens only at the frame start. Finally, a reset in mid-frame followed by a full frame confirms that the schedule restarts at slot 0.

// File: rtl/dfs_pkg.sv
`timescale 1ns/1ps
package dfs_pkg;
  localparam int SAMPLE_W = 12;
  localparam int WORD_W   = 16;
  localparam int SLOT_W   = 6;
  localparam int SLOTS    = 40;

  // slot boundaries of the fixed schedule
  localparam logic [SLOT_W-1:0] A_FIRST   = 6'd2;
  localparam logic [SLOT_W-1:0] A_LAST    = 6'd17;
  localparam logic [SLOT_W-1:0] B_FIRST   = 6'd22;
  localparam logic [SLOT_W-1:0] B_LAST    = 6'd37;
  localparam logic [SLOT_W-1:0] POST_SLOT = 6'd38;
  localparam logic [SLOT_W-1:0] LAST_SLOT = 6'(SLOTS - 1);

  typedef enum logic [2:0] {
    PH_PRE, PH_SHA, PH_GAP, PH_SHB, PH_POST, PH_LOAD
  } phase_e;

  function automatic phase_e phase_of(input logic [SLOT_W-1:0] s);
    if (s < A_FIRST)        return PH_PRE;
    else if (s <= A_LAST)   return PH_SHA;
    else if (s < B_FIRST)   return PH_GAP;
    else if (s <= B_LAST)   return PH_SHB;
    else if (s == POST_SLOT) return PH_POST;
    else                    return PH_LOAD;
  endfunction

  // command word: channel, unused 0, gain 1x, output enabled, sample
  function automatic logic [WORD_W-1:0] dac_word(input logic ch_b,
                                                 input logic [SAMPLE_W-1:0] s);
    return {ch_b, 1'b0, 1'b1, 1'b1, s};
  endfunction
endpackage

// File: rtl/dfs_tick.sv
`timescale 1ns/1ps
module dfs_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R9: enables are spaced at least two clocks apart
  p_tick_gap_r9: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/dfs_sched.sv
`timescale 1ns/1ps
module dfs_sched
  import dfs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  output phase_e phase,
  output logic   half,
  output logic   ld_a,
  output logic   ld_b,
  output logic   sh,
  output logic   wrap
);
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] nslot;
  logic              bnd;

  assign nslot = (slot == LAST_SLOT) ? '0 : slot + 1'b1;
  assign bnd   = tick && half;
  assign phase = phase_of(slot);

  // named slot-boundary events
  assign ld_a = bnd && (nslot == A_FIRST);
  assign ld_b = bnd && (nslot == B_FIRST);
  assign sh   = bnd && (((nslot > A_FIRST) && (nslot <= A_LAST)) ||
                        ((nslot > B_FIRST) && (nslot <= B_LAST)));
  assign wrap = bnd && (slot == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
      half <= 1'b0;
    end else if (tick) begin
      half <= ~half;
      if (half) slot <= nslot;
    end
  end

  p_slot_bound_r1: assert property (@(posedge clk) disable iff (rst)
    slot <= LAST_SLOT);
  p_wrap_from_load_r1: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (phase == PH_LOAD));
  p_load_not_shift_r4: assert property (@(posedge clk) disable iff (rst)
    !((ld_a || ld_b) && sh));
endmodule

// File: rtl/dfs_shift.sv
`timescale 1ns/1ps
module dfs_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         msb
);
  logic [W-1:0] q;

  assign msb = q[W-1];

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/dac_frame_seq.sv
`timescale 1ns/1ps
module dac_frame_seq
  import dfs_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] samp_a,
  input  logic [SAMPLE_W-1:0] samp_b,
  output logic                sck,
  output logic                mosi,
  output logic                cs_n,
  output logic                ldac_n,
  output logic                frame_done
);
  localparam int LW = $clog2(2 * HALF_DIV + 2);

  logic          tick;
  phase_e        phase;
  logic          half;
  logic          ld_a, ld_b, sh, wrap;
  logic          start_q, done_q;
  logic [SAMPLE_W-1:0] cap_a, cap_b;
  logic [WORD_W-1:0]   word_in;
  logic          sr_msb;
  logic          cs_low;

  dfs_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk (clk), .rst (rst), .tick (tick)
  );

  dfs_sched u_sched (
    .clk (clk), .rst (rst), .tick (tick), .phase (phase), .half (half),
    .ld_a (ld_a), .ld_b (ld_b), .sh (sh), .wrap (wrap)
  );

  // frame-start flag: first cycle after reset, and the cycle after a wrap
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      start_q <= wrap;
      done_q  <= wrap;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_a <= '0;
      cap_b <= '0;
    end else if (start_q) begin
      cap_a <= samp_a;
      cap_b <= samp_b;
    end
  end

  assign word_in = ld_b ? dac_word(1'b1, cap_b) : dac_word(1'b0, cap_a);

  dfs_shift #(.W(WORD_W)) u_shift (
    .clk (clk), .rst (rst), .load (ld_a || ld_b), .shift (sh),
    .din (word_in), .msb (sr_msb)
  );

  assign cs_low     = (phase == PH_SHA) || (phase == PH_SHB);
  assign cs_n       = !cs_low;
  assign sck        = cs_low && half;
  assign mosi       = cs_low ? sr_msb : 1'b0;
  assign ldac_n     = (phase != PH_LOAD);
  assign frame_done = done_q;

  // checker-side count of strobe width
  logic [LW-1:0] ldac_cnt;
  always_ff @(posedge clk) begin
    if (rst)         ldac_cnt <= '0;
    else if (ldac_n) ldac_cnt <= '0;
    else             ldac_cnt <= ldac_cnt + 1'b1;
  end

  p_ldac_cs_high_r6: assert property (@(posedge clk) disable iff (rst)
    !ldac_n |-> cs_n);
  p_ldac_width_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ldac_n) |-> (ldac_cnt == LW'(2 * HALF_DIV)));
  p_sck_idle_r3: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));
  p_first_bit_channel_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (mosi == (phase == PH_SHB)));
  p_done_single_r1: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
endmodule

// File: tb/sim_dac_frame_seq.sv
`timescale 1ns/1ps
module sim_dac_frame_seq;
  localparam int D     = 4;
  localparam int FRAME = 80 * D;
  localparam int NV    = 6;
  localparam logic [23:0] VEC [NV] = '{
    24'h000FFF, 24'hFFF000, 24'hA5A5A5, 24'h800001, 24'h123ABC, 24'h7FF800
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] samp_a = '0, samp_b = '0;
  logic sck, mosi, cs_n, ldac_n, frame_done;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dac_frame_seq #(.HALF_DIV(D)) u0 (
    .clk (clk), .rst (rst), .samp_a (samp_a), .samp_b (samp_b),
    .sck (sck), .mosi (mosi), .cs_n (cs_n), .ldac_n (ldac_n),
    .frame_done (frame_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  function automatic int exp_mosi(input int slot, input logic [11:0] a,
                                  input logic [11:0] b);
    int wa = 'h3000 + int'(a);
    int wb = 'hB000 + int'(b);
    if (slot >= 2 && slot <= 17)  return (wa >> (17 - slot)) & 1;
    if (slot >= 22 && slot <= 37) return (wb >> (37 - slot)) & 1;
    return 0;
  endfunction

  // walks n frames from reset release; samples must already hold VEC[first]
  task automatic run_frames(input int first, input int n);
    for (int e = 1; e <= FRAME * n; e++) begin
      int k, slot, hf, f, vi, nx;
      bit csl;
      @(posedge clk);
      @(negedge clk);
      k    = (e / D) % 80;
      slot = k / 2;
      hf   = k % 2;
      f    = e / FRAME;
      vi   = (first + f) % NV;
      csl  = (slot >= 2 && slot <= 17) || (slot >= 22 && slot <= 37);
      chk(cs_n == !csl, "R2 cs_n", int'(cs_n), int'(!csl));
      // R3 and R9: half-period of D clocks, low when deselected
      chk(sck == (csl && hf == 1), "R3/R9 sck", int'(sck), int'(csl && hf == 1));
      // R4, R5, R7: word bits from the frame's captured pair
      chk(int'(mosi) == exp_mosi(slot, VEC[vi][23:12], VEC[vi][11:0]),
          "R5 mosi", int'(mosi), exp_mosi(slot, VEC[vi][23:12], VEC[vi][11:0]));
      chk(ldac_n == (slot != 39), "R6 ldac_n", int'(ldac_n), int'(slot != 39));
      chk(frame_done == (e % FRAME == 0), "R1 frame_done",
          int'(frame_done), int'(e % FRAME == 0));
      nx = (first + f + 1) % NV;
      if (e % FRAME == 2) begin           // R7: junk after capture
        samp_a = ~VEC[nx][23:12];
        samp_b = ~VEC[nx][11:0];
      end else if (e % FRAME == FRAME / 2) begin
        samp_a = VEC[nx][23:12];
        samp_b = VEC[nx][11:0];
      end
    end
  endtask

  task automatic idle_check(input string tag);
    chk(cs_n == 1'b1, tag, int'(cs_n), 1);
    chk(ldac_n == 1'b1, tag, int'(ldac_n), 1);
    chk(sck == 1'b0, tag, int'(sck), 0);
    chk(mosi == 1'b0, tag, int'(mosi), 0);
    chk(frame_done == 1'b0, tag, int'(frame_done), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    samp_a = VEC[0][23:12];
    samp_b = VEC[0][11:0];
    repeat (3) @(posedge clk);
    @(negedge clk);
    idle_check("R8 reset idle");
    rst = 1'b0;
    run_frames(0, NV);               // table walk over all vectors
    repeat (150) @(posedge clk);     // stop mid-frame
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    idle_check("R8 mid-frame reset");
    samp_a = VEC[3][23:12];
    samp_b = VEC[3][11:0];
    rst = 1'b0;
    run_frames(3, 1);                // restart from slot 0
    finish_run();
  end
endmodule